// File: doc/BRIEF.md
# Programmed I/O Peripheral Interface

This block is the device-side controller that sits on a minicomputer's programmed I/O bus. Each bus cycle carries a 5-bit device address and a 3-bit function code, plus one strobe that names the kind of cycle: select (a command), sense (a readiness query), write (a processor word going to the device) or read (a device word going to the processor). The interface responds only when the address matches its strapped device number. The number 0 is reserved and never matches.

The interface holds one output word and one input word. Each has a ready flag, and a simple device model drives those flags from outside. Select cycles issue commands. A select with an all-zero data bus carries its meaning in the function code alone. A select-and-present cycle also carries a register value, which the interface latches into its mode register. Once the processor has enabled interrupts on the device, two kinds of event raise a request. The first is a normal device event (an output word taken or an input word delivered), which requests the normal vector. The second is an echo pulse from the processor addressed to this device, which requests a separate end-of-block vector. Both vectors are 9-bit strapped addresses. Only one request is shown at a time, and it stays up until acknowledged.

Top module: `pio_dev_if`

## Requirements
- R1: A cycle takes effect only when `io_addr` equals `cfg_addr` and `cfg_addr` is non-zero. With no match, `sense_resp` and `io_rdata` stay 0 and the registered state does not change.
- R2: A select with function code 4 loads `dev_mode` from `io_wdata` at the next edge. A plain select (data 0) therefore clears it. Select codes 3, 5, 6 and 7 leave `dev_mode` unchanged.
- R3: Select code 1 enables interrupts and code 2 disables them. Select code 0 does a full reset: mode 0, output ready, input empty, interrupts disabled, nothing pending and `int_req` low. This reset wins over any other event in the same cycle.
- R4: `sense_resp` responds in the same cycle. Sense code 0 returns 1 when the output register is free. Sense code 1 returns 1 when the input register holds a word. Every other sense code returns 0.
- R5: A write with code 0 while the output register is free loads `dev_out_data` and raises `dev_out_full`. A write while the register is full is ignored.
- R6: A read with code 1 returns the held input word on `io_rdata` in the same cycle and empties the input register.
- R7: The device model works as follows. `dev_out_take` while full frees the output register. `dev_in_valid` while the input register is empty stores `dev_in_data` and marks it full. Each of these strobes is ignored in the other state.
- R8: While interrupts are enabled, each accepted device strobe from R7 makes a normal request pending. While interrupts are disabled, such events are dropped.
- R9: An echo pulse addressed to this device while interrupts are enabled makes an end-of-block request pending.
- R10: A pending request appears on `int_req` one cycle after it becomes pending. `int_vec` shows `cfg_vec_norm` or `cfg_vec_eob`, and both stay stable until `int_ack`. If both requests are pending, the end-of-block one goes first. `int_vec` is 0 while no request is shown.
- R11: A request that arrives while another is shown is held. It appears in the second cycle after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 5 | Strapped device number |
| cfg_vec_norm | input | 9 | Strapped normal interrupt vector |
| cfg_vec_eob | input | 9 | Strapped end-of-block interrupt vector |
| io_addr | input | 5 | Bus device address |
| io_fc | input | 3 | Bus function code |
| io_sel | input | 1 | Select (command) cycle strobe |
| io_sense | input | 1 | Sense cycle strobe |
| io_wr | input | 1 | Processor-to-device data strobe |
| io_rd | input | 1 | Device-to-processor data strobe |
| io_echo | input | 1 | Echo pulse, qualified by `io_addr` |
| io_wdata | input | 16 | Data bus from processor |
| io_rdata | output | 16 | Data bus to processor |
| sense_resp | output | 1 | Sense response |
| int_req | output | 1 | Interrupt request |
| int_vec | output | 9 | Vector of the shown request |
| int_ack | input | 1 | Interrupt acknowledge |
| dev_mode | output | 16 | Mode register |
| dev_out_data | output | 16 | Output word to device |
| dev_out_full | output | 1 | Output register holds a word |
| dev_out_take | input | 1 | Device consumes the output word |
| dev_in_valid | input | 1 | Device delivers an input word |
| dev_in_data | input | 16 | Input word from device |

## Verification
The assertions assume that the bus presents at most one of select, sense, write and read in a cycle. They also assume that the strapped address and vectors stay constant while out of reset, and that `int_ack` is only raised while a request is shown. The stimulus keeps to these rules. It drives exactly one strobe per bus step, holds the strapping fixed after one early phase that checks address 0, and acknowledges only after it has seen `int_req` high.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Select command codes
  localparam int unsigned CMD_CLEAR   = 0;
  localparam int unsigned CMD_IRQ_ON  = 1;
  localparam int unsigned CMD_IRQ_OFF = 2;
  localparam int unsigned CMD_MODE    = 4;
  // Sense and transfer codes
  localparam int unsigned CODE_OUT    = 0;
  localparam int unsigned CODE_IN     = 1;

  typedef struct packed {
    logic clr;
    logic irq_on;
    logic irq_off;
    logic mode_ld;
    logic put_out;
    logic get_in;
    logic ask_out;
    logic ask_in;
    logic echo_hit;
  } pio_dec_t;

  // Arbitration: end-of-block wins over normal
  function automatic logic pick_eob(input logic pend_e, input logic pend_n);
    pick_eob = pend_e | ~pend_n;
  endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int FC_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [FC_W-1:0]   fc,
  input  logic              sel,
  input  logic              sense,
  input  logic              wr,
  input  logic              rd,
  input  logic              echo,
  output logic              hit,
  output pio_dec_t          dec
);

  function automatic logic fc_is(input logic [FC_W-1:0] f, input int unsigned code);
    fc_is = (f == FC_W'(code));
  endfunction

  always_comb begin
    hit          = (cfg_addr != '0) && (addr == cfg_addr);
    dec.clr      = hit && sel && fc_is(fc, CMD_CLEAR);
    dec.irq_on   = hit && sel && fc_is(fc, CMD_IRQ_ON);
    dec.irq_off  = hit && sel && fc_is(fc, CMD_IRQ_OFF);
    dec.mode_ld  = hit && sel && fc_is(fc, CMD_MODE);
    dec.put_out  = hit && wr && fc_is(fc, CODE_OUT);
    dec.get_in   = hit && rd && fc_is(fc, CODE_IN);
    dec.ask_out  = hit && sense && fc_is(fc, CODE_OUT);
    dec.ask_in   = hit && sense && fc_is(fc, CODE_IN);
    dec.echo_hit = hit && echo;
  end

endmodule

// File: rtl/pio_xfer.sv
module pio_xfer
  import pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pio_dec_t          dec,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_take,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] out_q,
  output logic              out_free,
  output logic [DATA_W-1:0] in_q,
  output logic              in_full,
  output logic              dev_event
);

  logic take_ok, fill_ok, put_ok;

  always_comb begin
    take_ok   = dev_take && !out_free;
    fill_ok   = dev_valid && !in_full;
    put_ok    = dec.put_out && out_free;
    dev_event = take_ok || fill_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      out_q    <= '0;
      out_free <= 1'b1;
      in_q     <= '0;
      in_full  <= 1'b0;
    end else if (dec.clr) begin
      mode_q   <= '0;
      out_free <= 1'b1;
      in_full  <= 1'b0;
    end else begin
      if (dec.mode_ld) mode_q <= wdata;
      if (put_ok) begin
        out_q    <= wdata;
        out_free <= 1'b0;
      end else if (take_ok) begin
        out_free <= 1'b1;
      end
      if (dec.get_in) begin
        in_full <= 1'b0;
      end else if (fill_ok) begin
        in_q    <= dev_data;
        in_full <= 1'b1;
      end
    end
  end

  assert_wr_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.put_out && !out_free && !dec.clr) |=> $stable(out_q));

  assert_fill_from_dev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_full) |-> $past(dev_valid));

  assert_clear_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec.clr |=> (out_free && !in_full && mode_q == '0));

endmodule

// File: rtl/pio_irq.sv
module pio_irq
  import pio_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             irq_on,
  input  logic             irq_off,
  input  logic             dev_event,
  input  logic             echo_hit,
  input  logic             ack,
  input  logic [VEC_W-1:0] vec_norm,
  input  logic [VEC_W-1:0] vec_eob,
  output logic             req,
  output logic [VEC_W-1:0] vec
);

  logic ien, pend_n, pend_e, cur_v, cur_e;
  logic ev_n, ev_e, load, load_e;

  always_comb begin
    ev_n   = ien && dev_event;
    ev_e   = ien && echo_hit;
    load   = !cur_v && (pend_n || pend_e);
    load_e = pick_eob(pend_e, pend_n);
    req    = cur_v;
    vec    = !cur_v ? '0 : (cur_e ? vec_eob : vec_norm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 1'b0; pend_n <= 1'b0; pend_e <= 1'b0;
      cur_v <= 1'b0; cur_e <= 1'b0;
    end else if (clr) begin
      ien <= 1'b0; pend_n <= 1'b0; pend_e <= 1'b0;
      cur_v <= 1'b0; cur_e <= 1'b0;
    end else begin
      if (irq_on) ien <= 1'b1;
      else if (irq_off) ien <= 1'b0;
      pend_n <= (pend_n && !(load && !load_e)) || ev_n;
      pend_e <= (pend_e && !(load && load_e)) || ev_e;
      if (cur_v && ack) begin
        cur_v <= 1'b0;
      end else if (load) begin
        cur_v <= 1'b1;
        cur_e <= load_e;
      end
    end
  end

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !clr) |=> (req && $stable(vec)));

  assert_req_from_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(pend_n || pend_e));

  assert_eob_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && pend_e && pend_n && !clr) |=> (vec == vec_eob));

endmodule

// File: rtl/pio_dev_if.sv
module pio_dev_if
  import pio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int FC_W   = 3,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [VEC_W-1:0]  cfg_vec_norm,
  input  logic [VEC_W-1:0]  cfg_vec_eob,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [FC_W-1:0]   io_fc,
  input  logic              io_sel,
  input  logic              io_sense,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_echo,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sense_resp,
  output logic              int_req,
  output logic [VEC_W-1:0]  int_vec,
  input  logic              int_ack,
  output logic [DATA_W-1:0] dev_mode,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              dev_out_full,
  input  logic              dev_out_take,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data
);

  pio_dec_t          dec;
  logic              hit;
  logic              out_free, in_full, dev_event;
  logic [DATA_W-1:0] in_q;

  pio_decode #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_dec (
    .addr(io_addr), .cfg_addr(cfg_addr), .fc(io_fc),
    .sel(io_sel), .sense(io_sense), .wr(io_wr), .rd(io_rd),
    .echo(io_echo), .hit(hit), .dec(dec)
  );

  pio_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .dec(dec), .wdata(io_wdata),
    .dev_take(dev_out_take), .dev_valid(dev_in_valid), .dev_data(dev_in_data),
    .mode_q(dev_mode), .out_q(dev_out_data), .out_free(out_free),
    .in_q(in_q), .in_full(in_full), .dev_event(dev_event)
  );

  pio_irq #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(dec.clr),
    .irq_on(dec.irq_on), .irq_off(dec.irq_off),
    .dev_event(dev_event), .echo_hit(dec.echo_hit), .ack(int_ack),
    .vec_norm(cfg_vec_norm), .vec_eob(cfg_vec_eob),
    .req(int_req), .vec(int_vec)
  );

  always_comb begin
    dev_out_full = !out_free;
    sense_resp   = (dec.ask_out && out_free) || (dec.ask_in && in_full);
    io_rdata     = dec.get_in ? in_q : '0;
  end

  assert_addr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == '0) |-> (!sense_resp && io_rdata == '0));

  assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!sense_resp && io_rdata == '0));

endmodule

// File: tb/test_pio_dev_if.sv
module test_pio_dev_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_addr = 5'd5;
  logic [8:0]  cfg_vec_norm = 9'h0A4;
  logic [8:0]  cfg_vec_eob  = 9'h1F2;
  logic [4:0]  io_addr = '0;
  logic [2:0]  io_fc = '0;
  logic        io_sel = 0, io_sense = 0, io_wr = 0, io_rd = 0, io_echo = 0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        sense_resp, int_req;
  logic [8:0]  int_vec;
  logic        int_ack = 0;
  logic [15:0] dev_mode, dev_out_data;
  logic        dev_out_full;
  logic        dev_out_take = 0, dev_in_valid = 0;
  logic [15:0] dev_in_data = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pio_dev_if i_pio_dev_if (.*);

  // reference state
  logic [15:0] m_mode = 0, m_out = 0, m_in = 0;
  logic m_free = 1, m_full = 0, m_ien = 0, m_pn = 0, m_pe = 0, m_cv = 0, m_ce = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_hit();
    return (cfg_addr != 0) && (io_addr == cfg_addr);
  endfunction

  task automatic model_edge();
    logic hit, ev_n, ev_e, load, le;
    hit  = m_hit();
    ev_n = m_ien && ((dev_out_take && !m_free) || (dev_in_valid && !m_full));
    ev_e = m_ien && io_echo && hit;
    if (hit && io_sel && io_fc == 0) begin
      m_mode = 0; m_free = 1; m_full = 0; m_ien = 0;
      m_pn = 0; m_pe = 0; m_cv = 0; m_ce = 0;
      return;
    end
    if (hit && io_sel && io_fc == 4) m_mode = io_wdata;
    if (m_free && hit && io_wr && io_fc == 0) begin m_out = io_wdata; m_free = 0; end
    else if (!m_free && dev_out_take) m_free = 1;
    if (hit && io_rd && io_fc == 1) m_full = 0;
    else if (!m_full && dev_in_valid) begin m_in = dev_in_data; m_full = 1; end
    load = !m_cv && (m_pn || m_pe);
    le = m_pe;
    if (hit && io_sel && io_fc == 1) m_ien = 1;
    else if (hit && io_sel && io_fc == 2) m_ien = 0;
    if (m_cv && int_ack) m_cv = 0;
    else if (load) begin m_cv = 1; m_ce = le; end
    if (load && le) m_pe = 0;
    if (load && !le) m_pn = 0;
    if (ev_e) m_pe = 1;
    if (ev_n) m_pn = 1;
  endtask

  task automatic step(input string tag);
    logic hit;
    #2;
    hit = m_hit();
    chk(tag, "sense_resp", sense_resp,
        hit && io_sense && ((io_fc == 0 && m_free) || (io_fc == 1 && m_full)));
    chk(tag, "io_rdata", io_rdata, (hit && io_rd && io_fc == 1) ? m_in : 0);
    chk(tag, "int_req", int_req, m_cv);
    chk(tag, "int_vec", int_vec, !m_cv ? 0 : (m_ce ? cfg_vec_eob : cfg_vec_norm));
    chk(tag, "dev_mode", dev_mode, m_mode);
    chk(tag, "dev_out_full", dev_out_full, !m_free);
    if (!m_free) chk(tag, "dev_out_data", dev_out_data, m_out);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    io_sel = 0; io_sense = 0; io_wr = 0; io_rd = 0; io_echo = 0;
    int_ack = 0; dev_out_take = 0; dev_in_valid = 0;
    io_addr = 5'd5; io_fc = 0; io_wdata = 0;
  endtask

  task automatic bus(input string tag, input int kind, input int a, input int f, input int d);
    idle();
    io_addr = 5'(a); io_fc = 3'(f); io_wdata = 16'(d);
    case (kind)
      0: io_sel = 1;
      1: io_sense = 1;
      2: io_wr = 1;
      3: io_rd = 1;
      default: io_echo = 1;
    endcase
    step(tag);
    idle();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R3 reset state");
    // R1: address zero strapping never matches
    cfg_addr = 0;
    bus("R1", 1, 0, 0, 0);
    bus("R1", 2, 0, 0, 16'h7777);
    cfg_addr = 5'd5;
    bus("R1", 1, 6, 0, 0);
    bus("R1", 2, 6, 0, 16'h3333);
    bus("R1", 0, 6, 4, 16'h00FF);
    // R4 sense codes
    bus("R4", 1, 5, 0, 0);
    bus("R4", 1, 5, 1, 0);
    bus("R4", 1, 5, 3, 0);
    bus("R4", 1, 5, 7, 0);
    // R2 mode register
    bus("R2", 0, 5, 4, 1);
    bus("R2", 0, 5, 4, 0);
    bus("R2", 0, 5, 4, 16'h1234);
    bus("R2", 0, 5, 5, 16'hFFFF);
    bus("R2", 0, 5, 3, 16'hFFFF);
    bus("R2", 0, 5, 7, 16'hFFFF);
    step("R2");
    // R5 output register
    bus("R5", 2, 5, 0, 16'hA5A5);
    bus("R5", 2, 5, 0, 16'h1111);
    bus("R5", 1, 5, 0, 0);
    // R7 device takes word, R8 interrupts disabled
    dev_out_take = 1; step("R7"); idle();
    dev_out_take = 1; step("R7"); idle();
    step("R8 disabled");
    // R3 enable, R8 normal request
    bus("R3", 0, 5, 1, 0);
    bus("R5", 2, 5, 0, 16'h5A5A);
    dev_out_take = 1; step("R8"); idle();
    step("R10"); step("R10"); step("R10");
    int_ack = 1; step("R10 ack"); idle();
    step("R10");
    // R7 input path and R6 read
    dev_in_data = 16'h0BEE; dev_in_valid = 1; step("R7"); idle();
    dev_in_data = 16'hDEAD; dev_in_valid = 1; step("R7 full"); idle();
    bus("R4", 1, 5, 1, 0);
    int_ack = 1; step("R10 ack"); idle();
    bus("R6", 3, 5, 1, 0);
    bus("R6", 1, 5, 1, 0);
    // R9 echo
    bus("R9", 4, 6, 0, 0);
    step("R9");
    bus("R9", 4, 5, 0, 0);
    step("R9"); step("R9");
    int_ack = 1; step("R9 ack"); idle();
    step("R9");
    // R10 / R11 both pending together
    dev_in_data = 16'h4242; dev_in_valid = 1; io_echo = 1; io_addr = 5'd5;
    step("R10 both"); idle();
    step("R10 eob first"); step("R10");
    int_ack = 1; step("R11 ack"); idle();
    step("R11"); step("R11"); step("R11");
    // R11 arrival while shown
    bus("R11", 4, 5, 0, 0);
    step("R11");
    bus("R6", 3, 5, 1, 0);
    dev_in_data = 16'h9999; dev_in_valid = 1; step("R11 held"); idle();
    step("R11"); step("R11");
    int_ack = 1; step("R11 ack"); idle();
    step("R11"); step("R11");
    int_ack = 1; step("R11 ack"); idle();
    step("R11");
    // R3 disable drops events
    bus("R3", 0, 5, 2, 0);
    bus("R5", 2, 5, 0, 16'hC0DE);
    dev_out_take = 1; step("R3 disabled"); idle();
    bus("R6", 3, 5, 1, 0);
    step("R3"); step("R3");
    // R3 clear command wins
    bus("R3", 0, 5, 1, 0);
    bus("R2", 0, 5, 4, 16'h0042);
    bus("R5", 2, 5, 0, 16'hBEEF);
    bus("R9", 4, 5, 0, 0);
    step("R3");
    dev_in_data = 16'h0101; dev_in_valid = 1; io_sel = 1; io_fc = 0; io_addr = 5'd5;
    step("R3 clear"); idle();
    step("R3"); step("R3");
    bus("R4", 1, 5, 0, 0);
    bus("R4", 1, 5, 1, 0);
    finish_run();
  end

endmodule